// File: doc/BRIEF.md
# Rotating Register File with Base Renaming

This block is an integer register file with a matching 64-bit predicate file. It is built for software-pipelined loops: one strobe moves every value in an upper window of registers up by one register number. The window starts at register 32 and its size is configurable. The same strobe moves predicates 16 to 63 up by one position. A loop kernel can then name the same registers on every pass while its data steps from one pipeline stage to the next.

The integer data never moves. A rename base is decremented modulo the window size, and every access to a window register passes through a small adder that computes the physical slot. The predicates are a single register of 64 bits and are shifted directly. Each shift loads predicate 16 from an input bit. That bit is held true while new iterations start and false while the pipeline drains. The whole predicate word can be read or written at once, so it can be saved and restored around a loop.

All ports are single-cycle and there is no back-pressure. Reads are combinational from the state as it stands. Writes, configuration changes and rotations take effect at the rising clock edge, and every input is accepted in the cycle it is presented.

Top module: `rot_regfile`

## Requirements
- R1: After reset, every integer register reads zero, the window size and rename base are zero, and the predicate word reads 64'h1.
- R2: A write to logical register L (L not 0) is visible on both read ports from the next cycle. Register 0 always reads zero and ignores writes.
- R3: A window size is accepted only when it is a multiple of 8 and no more than NUM_REGS-32. Any other value is ignored and the previous size stays in force, which shows in where values wrap during rotation.
- R4: On a rotate with a nonzero size S, the value readable at register L, for 32 <= L < 32+S, becomes readable at L+1. The value at 32+S-1 moves to 32.
- R5: Integer registers below 32 or at 32+S and above are never renamed by a rotate. Predicates 1 to 15 are never changed by a rotate.
- R6: On a rotate, predicate i takes the old value of predicate i-1 for 17 <= i <= 63, predicate 16 takes the inject bit, and the old predicate 63 is lost.
- R7: A bulk predicate write replaces all 64 bits from the next cycle. Bit 0 of the read word is always 1, whatever was written.
- R8: When a write and a rotate fall in the same cycle, the write uses the mapping from before the rotate, so the written value then reads at L+1 (or at 32 after a wrap).
- R9: An accepted size write resets the rename base to zero. Each register in the new window then reads the physical slot of its own number.
- R10: With size 0, rotates leave every integer register where it is, while the predicates still shift.
- R11: A read of a register in the same cycle as a write to it returns the old value.
- R12: A bulk predicate write in the same cycle as a rotate stores the written word already shifted by one rotation.
- R13: An accepted size write in the same cycle as a rotate leaves the base at zero, while the predicates still shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_addr_a | input | AW | Logical register number for read port A |
| rd_data_a | output | XLEN | Read port A data |
| rd_addr_b | input | AW | Logical register number for read port B |
| rd_data_b | output | XLEN | Read port B data |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | AW | Logical register number to write |
| wr_data | input | XLEN | Write data |
| pr_we | input | 1 | Bulk predicate write strobe |
| pr_wdata | input | 64 | Predicate word to write |
| pr_rdata | output | 64 | Current predicate word, bit 0 forced to 1 |
| cfg_we | input | 1 | Window size write strobe |
| cfg_size | input | SW | Requested window size in registers |
| rotate | input | 1 | Rotate integer window and predicates by one |
| rot_inject | input | 1 | Value loaded into predicate 16 on a rotate |

## Verification
Each directed phase sets the window size and then reads a register on both sides of the wrap point while rotating. Comparing window sizes 16, 24, 8 and 0 shows whether the modulo wraps at the configured size or at a stale one. Rejected sizes (12, and 104, which is above the limit) must leave the wrap point unchanged. Cycles that combine write with rotate, size write with rotate, and predicate write with rotate check that each operation uses the mapping from before the rotate and check the ordering between them. A long random phase mixes all the strobes, including size changes in the middle of a rotation sequence, which reshuffle the logical view.

// File: rtl/rrf_pkg.sv
`timescale 1ns/1ps
package rrf_pkg;
  // first register of the renamed integer window
  localparam int ROT_LO      = 32;
  // first predicate that shifts on a rotate
  localparam int PRED_ROT_LO = 16;
  // predicate file width
  localparam int PRED_W      = 64;
  // window sizes must be a multiple of this
  localparam int ROT_GRAN    = 8;
endpackage

// File: rtl/rrf_rot_ctrl.sv
`timescale 1ns/1ps
// Holds the window size and the rename base.
module rrf_rot_ctrl
  import rrf_pkg::*;
#(
  parameter int NUM_REGS = 128,
  parameter int SW       = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [SW-1:0] cfg_size,
  input  logic          rotate,
  output logic [SW-1:0] size_q,
  output logic [SW-1:0] base_q
);
  localparam int ROT_MAX = NUM_REGS - ROT_LO;
  localparam int GB      = $clog2(ROT_GRAN);

  logic cfg_ok;
  assign cfg_ok = cfg_we && (cfg_size[GB-1:0] == '0) && (int'(cfg_size) <= ROT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_q <= '0;
      base_q <= '0;
    end else if (cfg_ok) begin
      size_q <= cfg_size;
      base_q <= '0;
    end else if (rotate && (size_q != '0)) begin
      base_q <= (base_q == '0) ? size_q - SW'(1) : base_q - SW'(1);
    end
  end
endmodule

// File: rtl/rrf_rename.sv
`timescale 1ns/1ps
// Logical to physical register number for one access port.
module rrf_rename
  import rrf_pkg::*;
#(
  parameter int AW = 7,
  parameter int SW = 7
) (
  input  logic [AW-1:0] laddr,
  input  logic [SW-1:0] size,
  input  logic [SW-1:0] base,
  output logic [AW-1:0] paddr
);
  localparam int EW = AW + 1;

  logic [EW-1:0] l_ext, lim, rel, sum, wrapped;
  logic          in_win;

  always_comb begin
    l_ext   = EW'(laddr);
    lim     = EW'(ROT_LO) + EW'(size);
    in_win  = (size != '0) && (l_ext >= EW'(ROT_LO)) && (l_ext < lim);
    rel     = l_ext - EW'(ROT_LO);
    sum     = rel + EW'(base);
    wrapped = (sum >= EW'(size)) ? sum - EW'(size) : sum;
    paddr   = in_win ? AW'(wrapped + EW'(ROT_LO)) : laddr;
  end
endmodule

// File: rtl/rrf_pred.sv
`timescale 1ns/1ps
// Predicate word with a shifting upper region.
module rrf_pred
  import rrf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pr_we,
  input  logic [PRED_W-1:0] pr_wdata,
  input  logic              rotate,
  input  logic              rot_inject,
  output logic [PRED_W-1:0] pr_rdata
);
  logic [PRED_W-1:0] pred_q, src, nxt;

  always_comb begin
    src = pr_we ? pr_wdata : pred_q;
    nxt = src;
    if (rotate) begin
      for (int i = PRED_ROT_LO + 1; i < PRED_W; i++) nxt[i] = src[i-1];
      nxt[PRED_ROT_LO] = rot_inject;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pred_q <= PRED_W'(1);
    else        pred_q <= nxt;
  end

  assign pr_rdata = {pred_q[PRED_W-1:1], pred_q[0] | 1'b1};
endmodule

// File: rtl/rot_regfile.sv
`timescale 1ns/1ps
module rot_regfile
  import rrf_pkg::*;
#(
  parameter int XLEN     = 64,
  parameter int NUM_REGS = 128,
  parameter int AW       = $clog2(NUM_REGS),
  parameter int SW       = $clog2(NUM_REGS - 32 + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     rd_addr_a,
  output logic [XLEN-1:0]   rd_data_a,
  input  logic [AW-1:0]     rd_addr_b,
  output logic [XLEN-1:0]   rd_data_b,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [XLEN-1:0]   wr_data,
  input  logic              pr_we,
  input  logic [63:0]       pr_wdata,
  output logic [63:0]       pr_rdata,
  input  logic              cfg_we,
  input  logic [SW-1:0]     cfg_size,
  input  logic              rotate,
  input  logic              rot_inject
);
  localparam int NPORT = 3; // read A, read B, write

  logic [SW-1:0]   rot_size, rot_base;
  logic [AW-1:0]   lad [NPORT];
  logic [AW-1:0]   pad [NPORT];
  logic [XLEN-1:0] mem [NUM_REGS];

  rrf_rot_ctrl #(.NUM_REGS(NUM_REGS), .SW(SW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_size(cfg_size),
    .rotate(rotate), .size_q(rot_size), .base_q(rot_base)
  );

  assign lad[0] = rd_addr_a;
  assign lad[1] = rd_addr_b;
  assign lad[2] = wr_addr;

  for (genvar p = 0; p < NPORT; p++) begin : g_ren
    rrf_rename #(.AW(AW), .SW(SW)) u_ren (
      .laddr(lad[p]), .size(rot_size), .base(rot_base), .paddr(pad[p])
    );
  end

  // write uses this cycle's mapping, i.e. the one before any rotate
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) mem[i] <= '0;
    end else if (wr_en && (wr_addr != '0)) begin
      mem[pad[2]] <= wr_data;
    end
  end

  assign rd_data_a = (rd_addr_a == '0) ? '0 : mem[pad[0]];
  assign rd_data_b = (rd_addr_b == '0) ? '0 : mem[pad[1]];

  rrf_pred u_pred (
    .clk(clk), .rst_n(rst_n), .pr_we(pr_we), .pr_wdata(pr_wdata),
    .rotate(rotate), .rot_inject(rot_inject), .pr_rdata(pr_rdata)
  );
endmodule

// File: rtl/rot_regfile_chk.sv
`timescale 1ns/1ps
module rot_regfile_chk #(
  parameter int XLEN = 64,
  parameter int AW   = 7,
  parameter int SW   = 7
) (
  input logic            clk,
  input logic            rst_n,
  input logic [AW-1:0]   rd_addr_a,
  input logic [XLEN-1:0] rd_data_a,
  input logic [AW-1:0]   rd_addr_b,
  input logic [XLEN-1:0] rd_data_b,
  input logic            wr_en,
  input logic [AW-1:0]   wr_addr,
  input logic [XLEN-1:0] wr_data,
  input logic            pr_we,
  input logic [63:0]     pr_wdata,
  input logic [63:0]     pr_rdata,
  input logic            cfg_we,
  input logic            rotate,
  input logic            rot_inject,
  input logic [SW-1:0]   rot_size
);
  logic [AW:0] nxt_a, top_a;
  logic        in_win_a;

  always_comb begin
    top_a    = (AW+1)'(32) + (AW+1)'(rot_size);
    in_win_a = (rot_size != '0) && ({1'b0, rd_addr_a} >= (AW+1)'(32)) &&
               ({1'b0, rd_addr_a} < top_a);
    nxt_a    = {1'b0, rd_addr_a} + (AW+1)'(1);
    if (nxt_a == top_a) nxt_a = (AW+1)'(32);
  end

  // R2
  wr_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr != '0 && !rotate && !cfg_we) |=>
      ((rd_addr_a != $past(wr_addr)) || (rd_data_a == $past(wr_data))));

  // R4
  rot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rotate && !cfg_we && !wr_en && in_win_a) |=>
      (({1'b0, rd_addr_b} != $past(nxt_a)) || (rd_data_b == $past(rd_data_a))));

  // R5
  pred_low_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rotate && !pr_we) |=> (pr_rdata[15:0] == $past(pr_rdata[15:0])));

  // R6
  pred_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rotate && !pr_we) |=> (pr_rdata[63:17] == $past(pr_rdata[62:16])));

  // R6
  pred_inject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rotate |=> (pr_rdata[16] == $past(rot_inject)));

  // R7
  pred_bulk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pr_we && !rotate) |=> (pr_rdata[63:1] == $past(pr_wdata[63:1])));
endmodule

bind rot_regfile rot_regfile_chk #(.XLEN(XLEN), .AW(AW), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
  .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b), .wr_en(wr_en),
  .wr_addr(wr_addr), .wr_data(wr_data), .pr_we(pr_we), .pr_wdata(pr_wdata),
  .pr_rdata(pr_rdata), .cfg_we(cfg_we), .rotate(rotate),
  .rot_inject(rot_inject), .rot_size(rot_size)
);

// File: tb/rot_regfile_bench.sv
`timescale 1ns/1ps
module rot_regfile_bench;
  localparam int XLEN = 64;
  localparam int NREG = 128;
  localparam int AW   = 7;
  localparam int SW   = 7;
  localparam int WMAX = NREG - 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [AW-1:0]   rd_addr_a = '0, rd_addr_b = '0, wr_addr = '0;
  logic [XLEN-1:0] wr_data = '0;
  logic            wr_en = 1'b0, pr_we = 1'b0, cfg_we = 1'b0;
  logic            rotate = 1'b0, rot_inject = 1'b0;
  logic [63:0]     pr_wdata = '0;
  logic [SW-1:0]   cfg_size = '0;
  logic [XLEN-1:0] rd_data_a, rd_data_b;
  logic [63:0]     pr_rdata;

  always #2.5 clk = ~clk;

  rot_regfile u_rot_regfile (
    .clk(clk), .rst_n(rst_n), .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
    .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .pr_we(pr_we), .pr_wdata(pr_wdata),
    .pr_rdata(pr_rdata), .cfg_we(cfg_we), .cfg_size(cfg_size),
    .rotate(rotate), .rot_inject(rot_inject)
  );

  // reference model: logical view of every register
  logic [XLEN-1:0] m_reg [NREG];
  int              m_size = 0;
  int              m_rot  = 0;   // rotations since the last accepted size
  logic [63:0]     m_pred = 64'h1;
  int              checks = 0, fails = 0;
  bit              done = 0;

  task automatic cmp(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    logic [XLEN-1:0] ea, eb;
    ea = (rd_addr_a == 0) ? '0 : m_reg[rd_addr_a];
    eb = (rd_addr_b == 0) ? '0 : m_reg[rd_addr_b];
    cmp(tag, $sformatf("rd_a[%0d]", rd_addr_a), rd_data_a, ea);
    cmp(tag, $sformatf("rd_b[%0d]", rd_addr_b), rd_data_b, eb);
    cmp(tag, "pred", pr_rdata, {m_pred[63:1], 1'b1});
  endtask

  task automatic model_update();
    logic [XLEN-1:0] old [NREG];
    logic [63:0] w;
    int nsz;
    bit acc;
    if (wr_en && wr_addr != 0) m_reg[wr_addr] = wr_data;
    for (int i = 0; i < NREG; i++) old[i] = m_reg[i];
    nsz = int'(cfg_size);
    acc = cfg_we && (nsz % 8 == 0) && (nsz <= WMAX);
    if (acc) begin
      // base back to zero: each slot shows its own physical content again
      for (int j = 0; j < m_size; j++) m_reg[32+j] = old[32 + ((j + m_rot) % m_size)];
      m_size = nsz;
      m_rot  = 0;
    end else if (rotate && m_size > 0) begin
      for (int j = 0; j < m_size; j++) m_reg[32 + ((j + 1) % m_size)] = old[32+j];
      m_rot = (m_rot + 1) % m_size;
    end
    w = pr_we ? pr_wdata : m_pred;
    if (rotate) begin
      for (int i = 63; i > 16; i--) w[i] = w[i-1];
      w[16] = rot_inject;
    end
    m_pred = w;
  endtask

  // inputs set at the falling edge, compared 1 ns later, model stepped at the rising edge
  task automatic tick(string tag);
    #1;
    check_all(tag);
    @(posedge clk);
    #0.5;
    model_update();
    @(negedge clk);
  endtask

  task automatic idle();
    wr_en = 0; pr_we = 0; cfg_we = 0; rotate = 0; rot_inject = 0;
  endtask

  task automatic wr(int a, logic [XLEN-1:0] d, string tag);
    idle(); wr_en = 1; wr_addr = AW'(a); wr_data = d; tick(tag); idle();
  endtask

  task automatic rd(int a, int b, string tag);
    idle(); rd_addr_a = AW'(a); rd_addr_b = AW'(b); tick(tag);
  endtask

  task automatic cfg(int s, string tag);
    idle(); cfg_we = 1; cfg_size = SW'(s); tick(tag); idle();
  endtask

  task automatic rot(int a, int b, bit inj, string tag);
    idle(); rotate = 1; rot_inject = inj; rd_addr_a = AW'(a); rd_addr_b = AW'(b);
    tick(tag); idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NREG; i++) m_reg[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(0, 1, "R1"); rd(31, 32, "R1"); rd(64, 127, "R1");
    // R2 write/read and register 0
    wr(5, 64'h1111_2222_3333_4444, "R2");
    wr(40, 64'hAAAA_0000_0000_0040, "R2");
    wr(127, 64'hDEAD_BEEF_0000_007F, "R2");
    wr(0, 64'hFFFF_FFFF_FFFF_FFFF, "R2");
    rd(5, 0, "R2"); rd(40, 127, "R2");
    // R11 read in the write cycle returns the old value
    idle(); rd_addr_a = 5; rd_addr_b = 5; wr_en = 1; wr_addr = 5; wr_data = 64'h55; tick("R11");
    idle(); rd(5, 5, "R11");
    // R3 accepted size 16, fill window
    cfg(16, "R3");
    for (int i = 0; i < 16; i++) wr(32 + i, 64'h1000 + i, "R3");
    wr(48, 64'h4848, "R5");
    wr(10, 64'h1010, "R5");
    cfg(12, "R3");
    cfg(104, "R3");
    // R4 rotations with reads across the wrap, R5 untouched neighbours
    for (int k = 0; k < 18; k++) begin
      rot(32 + (k % 16), 47, 1'b1, "R4");
      rd(33, 32, "R3");
      rd(10, 48, "R5");
    end
    // R8 write together with rotate
    idle(); rotate = 1; wr_en = 1; wr_addr = 47; wr_data = 64'h8888; rd_addr_a = 47; rd_addr_b = 32;
    tick("R8"); idle();
    rd(32, 47, "R8");
    idle(); rotate = 1; wr_en = 1; wr_addr = 35; wr_data = 64'h3535; tick("R8"); idle();
    rd(36, 35, "R8");
    // R9 resize in mid-rotation resets the base
    rot(33, 34, 1'b0, "R9"); rot(33, 34, 1'b1, "R9");
    cfg(24, "R9");
    for (int i = 32; i < 56; i += 2) rd(i, i + 1, "R9");
    for (int i = 48; i < 56; i++) wr(i, 64'h2400 + i, "R9");
    rot(55, 32, 1'b1, "R9"); rd(55, 32, "R9");
    // R13 resize with rotate
    idle(); cfg_we = 1; cfg_size = 8; rotate = 1; rot_inject = 1; tick("R13"); idle();
    for (int i = 32; i < 40; i += 2) rd(i, i + 1, "R13");
    rot(39, 32, 1'b0, "R13"); rd(32, 40, "R13");
    // R10 size 0: no integer movement, predicates move
    cfg(0, "R10");
    for (int k = 0; k < 4; k++) rot(32 + k, 33 + k, k[0], "R10");
    rd(33, 34, "R10");
    // R7 bulk predicate write, bit 0 reads 1
    idle(); pr_we = 1; pr_wdata = 64'hF0F0_0F0F_A5A5_5A5A; tick("R7"); idle();
    rd(0, 0, "R7");
    idle(); pr_we = 1; pr_wdata = 64'h0; tick("R7"); idle();
    rd(0, 0, "R7");
    // R6 predicate shift with inject
    idle(); pr_we = 1; pr_wdata = 64'h8000_0000_0001_FFFE; tick("R6"); idle();
    for (int k = 0; k < 6; k++) rot(1, 2, (k < 3), "R6");
    // R12 predicate write with rotate
    idle(); pr_we = 1; pr_wdata = 64'hC000_0000_0003_7FFF; rotate = 1; rot_inject = 0; tick("R12"); idle();
    rd(3, 4, "R12");
    // mixed random traffic
    for (int n = 0; n < 3000; n++) begin
      idle();
      rd_addr_a  = AW'($urandom_range(0, NREG - 1));
      rd_addr_b  = ($urandom_range(0, 1) == 1) ? AW'(rd_addr_a + 1) : AW'($urandom_range(0, NREG - 1));
      wr_en      = ($urandom_range(0, 2) == 0);
      wr_addr    = AW'($urandom_range(0, NREG - 1));
      wr_data    = {$urandom, $urandom};
      rotate     = ($urandom_range(0, 1) == 1);
      rot_inject = ($urandom_range(0, 1) == 1);
      pr_we      = ($urandom_range(0, 15) == 0);
      pr_wdata   = {$urandom, $urandom};
      cfg_we     = ($urandom_range(0, 40) == 0);
      cfg_size   = SW'($urandom_range(0, 104));
      tick("R4");
    end
    idle();
    rd(0, 0, "R4");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule